// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block sits beside the address stage of a small processor pipeline and decides, for every memory request, whether the access breaks the alignment rules. It sees the request address, the access size, whether the request is an instruction fetch or a data access, whether address translation is on, the alignment-check control bit, and a table of eight memory-attribute bytes together with the attribute index that translation supplies. From these it works out a memory kind, which is either Device or Normal.

An unaligned access to Device memory always faults. An unaligned access to Normal memory faults only when the alignment-check bit is set. With translation off, data accesses are treated as Device and fetches as Normal. When a fault is found, the block raises a one-cycle synchronous exception pulse on the next clock. In the same cycle it loads a 32-bit syndrome word, the faulting address, and the handler address (vector base plus 0x200). These three registers keep their values until the next fault.

Top module: `align_fault_unit`

## Requirements
- R1: For Normal memory, an unaligned data access faults when `align_chk_en` is 1 and proceeds without a fault when it is 0.
- R2: For Device memory, an unaligned data access always faults, whatever `align_chk_en` holds.
- R3: With `mmu_en` = 0, data accesses use the Device rule and fetches use the Normal rule, regardless of the attribute inputs.
- R4: With `mmu_en` = 1, a data access takes the attribute byte `attr_table[8*attr_idx+7 : 8*attr_idx]`. An upper nibble of 0000 means Device. Any other value means Normal.
- R5: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An access is aligned when its low log2(bytes) address bits are zero, so a 1-byte access never faults. For example, a 4-byte Device access passes at 0x3E60, 0x3E64 and 0x3E68, and faults at 0x3E61 through 0x3E63 and 0x3E65 through 0x3E67.
- R6: A fetch is checked against 4-byte alignment, ignoring `req_size`, under the Normal rule.
- R7: The syndrome holds the exception class in bits [31:26] (0b100101 for data and 0b100001 for a fetch), bit 25 = 1, and 0x21 in bits [5:0]. All other bits are zero. This gives 0x96000021 for data and 0x86000021 for a fetch.
- R8: The vector output equals `vec_base` + 0x200 (modulo 2^ADDR_W), taken from the faulting cycle.
- R9: `exc_pulse` is 1 exactly in the cycle after a valid faulting request. It stays 0 after non-faulting or invalid requests.
- R10: Reset clears all outputs to zero. The syndrome, faulting-address and vector registers change only on a fault, and then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Virtual address of the request |
| req_size | input | 2 | Access size code (0..3 = 1, 2, 4, 8 bytes) |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| mmu_en | input | 1 | Address translation enabled |
| align_chk_en | input | 1 | Alignment-check control bit |
| attr_idx | input | IDX_W | Attribute slot chosen by translation |
| attr_table | input | 8<<IDX_W | Packed attribute bytes, slot s at bits [8s+7:8s] |
| vec_base | input | ADDR_W | Exception vector base |
| exc_pulse | output | 1 | One-cycle synchronous exception |
| exc_syndrome | output | 32 | Syndrome of the last fault |
| exc_fault_addr | output | ADDR_W | Address of the last fault |
| exc_vector | output | ADDR_W | Handler address of the last fault |

## Verification
The bench builds the block with its defaults, ADDR_W = 64 and IDX_W = 3. All eight attribute slots can therefore be selected, and a vector base near the top of the 64-bit space exercises the wrap of the +0x200 addition. These widths also let every size code meet address bits above bit 2, which shows that only the low log2(size) bits matter.

// File: rtl/align_fault_pkg.sv
// Shared types and constants for the alignment fault checker.
// Assumes a 32-bit syndrome layout: class[31:26], length bit 25, status[5:0].
package align_fault_pkg;

    typedef enum logic {
        MEM_DEVICE = 1'b0,
        MEM_NORMAL = 1'b1
    } mem_kind_e;

    localparam logic [5:0] EC_DATA_CUR  = 6'b100101;
    localparam logic [5:0] EC_FETCH_CUR = 6'b100001;
    localparam logic [5:0] FSC_ALIGN    = 6'h21;

    // Assemble a syndrome word for an alignment fault of the given kind.
    function automatic logic [31:0] make_syndrome(input logic is_fetch);
        logic [5:0] ec;
        ec = is_fetch ? EC_FETCH_CUR : EC_DATA_CUR;
        return {ec, 1'b1, 19'd0, FSC_ALIGN};
    endfunction

endpackage

// File: rtl/align_attr_sel.sv
// Works out the memory kind of a request.
// Assumes attribute slot s sits at attr_table[8s+7:8s]; an upper nibble of
// zero means Device. Fetches are always Normal; data with translation off is Device.
module align_attr_sel
    import align_fault_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                 mmu_en,
    input  logic                 is_fetch,
    input  logic [IDX_W-1:0]     attr_idx,
    input  logic [(8<<IDX_W)-1:0] attr_table,
    output mem_kind_e            mem_kind
);
    localparam int SLOTS = 1 << IDX_W;

    logic [7:0] slot_byte [SLOTS];
    logic [7:0] chosen;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_byte[s] = attr_table[s*8 +: 8];
    end

    assign chosen = slot_byte[attr_idx];

    // Pick the memory kind from request type, translation state and attribute.
    always_comb begin
        if (is_fetch)
            mem_kind = MEM_NORMAL;
        else if (!mmu_en)
            mem_kind = MEM_DEVICE;
        else if (chosen[7:4] == 4'b0000)
            mem_kind = MEM_DEVICE;
        else
            mem_kind = MEM_NORMAL;
    end
endmodule

// File: rtl/align_misalign_chk.sv
// Flags an address whose low log2(size) bits are not all zero.
// Assumes ADDR_W >= 3. Fetches use the 4-byte rule whatever the size code.
module align_misalign_chk #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              is_fetch,
    output logic              misaligned
);
    localparam int NSIZES = 4;
    localparam logic [1:0] FETCH_SIZE = 2'd2;

    logic [NSIZES-1:0] low_nz;

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        if (g == 0) begin : g_byte
            assign low_nz[g] = 1'b0;
        end else begin : g_wide
            assign low_nz[g] = |addr[g-1:0];
        end
    end

    // Select the alignment test for the effective size.
    always_comb begin
        misaligned = is_fetch ? low_nz[FETCH_SIZE] : low_nz[size];
    end
endmodule

// File: rtl/align_exc_regs.sv
// Registers the exception pulse, syndrome, faulting address and vector.
// Assumes a fault indication valid in the request cycle; values hold between faults.
module align_exc_regs
    import align_fault_pkg::*;
#(
    parameter int           ADDR_W  = 64,
    parameter int unsigned  VEC_OFF = 32'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              is_fetch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] vec_base,
    output logic              exc_pulse,
    output logic [31:0]       exc_syndrome,
    output logic [ADDR_W-1:0] exc_fault_addr,
    output logic [ADDR_W-1:0] exc_vector
);
    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(VEC_OFF);

    // Capture the exception record on a fault, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_pulse      <= 1'b0;
            exc_syndrome   <= '0;
            exc_fault_addr <= '0;
            exc_vector     <= '0;
        end else begin
            exc_pulse <= fault;
            if (fault) begin
                exc_syndrome   <= make_syndrome(is_fetch);
                exc_fault_addr <= addr;
                exc_vector     <= vec_base + OFFSET;
            end
        end
    end
endmodule

// File: rtl/align_fault_unit.sv
// Top of the alignment fault checker: decides the memory kind, tests alignment,
// applies the fault rule and registers the exception record.
// Assumes one request per cycle qualified by req_valid.
module align_fault_unit
    import align_fault_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic                  req_is_fetch,
    input  logic                  mmu_en,
    input  logic                  align_chk_en,
    input  logic [IDX_W-1:0]      attr_idx,
    input  logic [(8<<IDX_W)-1:0] attr_table,
    input  logic [ADDR_W-1:0]     vec_base,
    output logic                  exc_pulse,
    output logic [31:0]           exc_syndrome,
    output logic [ADDR_W-1:0]     exc_fault_addr,
    output logic [ADDR_W-1:0]     exc_vector
);
    mem_kind_e kind;
    logic      misaligned;
    logic      fault;

    align_attr_sel #(.IDX_W(IDX_W)) attr_i (
        .mmu_en     (mmu_en),
        .is_fetch   (req_is_fetch),
        .attr_idx   (attr_idx),
        .attr_table (attr_table),
        .mem_kind   (kind)
    );

    align_misalign_chk #(.ADDR_W(ADDR_W)) mis_i (
        .addr       (req_addr),
        .size       (req_size),
        .is_fetch   (req_is_fetch),
        .misaligned (misaligned)
    );

    // Device always faults when unaligned; Normal only with the check bit set.
    always_comb begin
        fault = req_valid && misaligned && ((kind == MEM_DEVICE) || align_chk_en);
    end

    align_exc_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault          (fault),
        .is_fetch       (req_is_fetch),
        .addr           (req_addr),
        .vec_base       (vec_base),
        .exc_pulse      (exc_pulse),
        .exc_syndrome   (exc_syndrome),
        .exc_fault_addr (exc_fault_addr),
        .exc_vector     (exc_vector)
    );
endmodule

// File: rtl/align_fault_chk.sv
// Property checker for align_fault_unit, attached by bind below.
module align_fault_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_is_fetch,
    input logic              mmu_en,
    input logic              align_chk_en,
    input logic [ADDR_W-1:0] vec_base,
    input logic              exc_pulse,
    input logic [31:0]       exc_syndrome,
    input logic [ADDR_W-1:0] exc_fault_addr,
    input logic [ADDR_W-1:0] exc_vector
);
    // R9
    pulse_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> $past(req_valid));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pulse |-> $stable(exc_fault_addr));

    // R8
    vector_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> (exc_vector == $past(vec_base) + ADDR_W'(32'h200)));

    // R2
    device_word_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_fetch && !mmu_en && req_size == 2'd2 && req_addr[1:0] != 2'b00)
        |=> exc_pulse);

    // R5
    byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_fetch && req_size == 2'd0) |=> !exc_pulse);

    // R6
    fetch_unchecked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_fetch && !align_chk_en) |=> !exc_pulse);

    // R7
    syndrome_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> (exc_syndrome[25:0] == 26'h2000021));
endmodule

bind align_fault_unit align_fault_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .req_is_fetch   (req_is_fetch),
    .mmu_en         (mmu_en),
    .align_chk_en   (align_chk_en),
    .vec_base       (vec_base),
    .exc_pulse      (exc_pulse),
    .exc_syndrome   (exc_syndrome),
    .exc_fault_addr (exc_fault_addr),
    .exc_vector     (exc_vector)
);

// File: tb/align_fault_unit_tb.sv
// Bench for align_fault_unit: behavioural reference model compared every clock.
module align_fault_unit_tb_top;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [ADDR_W-1:0]     req_addr = '0;
    logic [1:0]            req_size = '0;
    logic                  req_is_fetch = 1'b0;
    logic                  mmu_en = 1'b0;
    logic                  align_chk_en = 1'b0;
    logic [IDX_W-1:0]      attr_idx = '0;
    logic [(8<<IDX_W)-1:0] attr_table = '0;
    logic [ADDR_W-1:0]     vec_base = '0;
    logic                  exc_pulse;
    logic [31:0]           exc_syndrome;
    logic [ADDR_W-1:0]     exc_fault_addr;
    logic [ADDR_W-1:0]     exc_vector;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R10";

    always #5 clk = ~clk;

    align_fault_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (.*);

    // Reference state
    bit              m_pulse = 0;
    logic [31:0]     m_synd = '0;
    logic [63:0]     m_addr = '0;
    logic [63:0]     m_vec = '0;

    function automatic bit ref_fault();
        int bytes;
        int attr;
        bit dev;
        if (!req_valid) return 0;
        if (req_is_fetch) return align_chk_en && (req_addr % 4 != 0);
        bytes = 1 << req_size;
        if (req_addr % bytes == 0) return 0;
        if (!mmu_en) dev = 1;
        else begin
            attr = int'((attr_table >> (8 * attr_idx)) & 64'hFF);
            dev = (attr < 16);
        end
        return dev ? 1'b1 : align_chk_en;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pulse = 0; m_synd = '0; m_addr = '0; m_vec = '0;
        end else begin
            m_pulse = ref_fault();
            if (m_pulse) begin
                m_synd = req_is_fetch ? 32'h8600_0021 : 32'h9600_0021;
                m_addr = req_addr;
                m_vec  = vec_base + 64'h200;
            end
        end
    end

    task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cmp("pulse (R9)", 64'(exc_pulse), 64'(m_pulse));
        cmp("syndrome (R7)", 64'(exc_syndrome), 64'(m_synd));
        cmp("fault_addr (R10)", exc_fault_addr, m_addr);
        cmp("vector (R8)", exc_vector, m_vec);
    end

    task automatic drive(bit v, logic [63:0] a, logic [1:0] sz, bit f, bit mmu, bit chk, int idx);
        @(negedge clk);
        req_valid = v; req_addr = a; req_size = sz; req_is_fetch = f;
        mmu_en = mmu; align_chk_en = chk; attr_idx = IDX_W'(idx);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        vec_base = 64'h0;
        // slot 0 Device (0x00), slot 1 Normal (0xFF), slot 2 Device (0x0C), slot 3 Normal (0x44)
        attr_table = 64'h4444_4444_440C_FF00;
        repeat (3) @(negedge clk);
        tag = "R10 reset";
        rst_n = 1'b1;

        // R3/R2/R5: data, translation off -> Device, 4-byte at the example addresses
        tag = "R2/R3/R5 device word";
        for (int a = 'h3E60; a <= 'h3E68; a++) drive(1, 64'(a), 2'd2, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);

        // R3: fetch with translation off is Normal; check bit off -> no fault
        tag = "R3 fetch normal";
        drive(1, 64'h3E61, 2'd2, 1, 0, 0, 0);
        drive(1, 64'h3E62, 2'd3, 1, 0, 0, 0);
        // R6: fetch uses 4-byte rule whatever size, check on
        tag = "R6 fetch 4B rule";
        drive(1, 64'h1002, 2'd0, 1, 0, 1, 0);
        drive(1, 64'h1004, 2'd3, 1, 0, 1, 0);
        drive(1, 64'h1001, 2'd1, 1, 1, 1, 0);

        // R1: Normal memory via slot 1
        tag = "R1 normal chk";
        drive(1, 64'h2001, 2'd2, 0, 1, 0, 1);
        drive(1, 64'h2001, 2'd2, 0, 1, 1, 1);
        drive(1, 64'h2004, 2'd3, 0, 1, 1, 1);
        drive(1, 64'h2004, 2'd2, 0, 1, 1, 1);

        // R4: slot selection, slot 2 (0x0C) Device, slot 3 (0x44) Normal
        tag = "R4 attr slots";
        for (int s = 0; s < 8; s++) drive(1, 64'h3003, 2'd1, 0, 1, 0, s);

        // R5: each size code at every low address offset, Device and Normal
        tag = "R5 sizes";
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 9; off++) begin
                drive(1, 64'h5550 + 64'(off), 2'(sz), 0, 0, 0, 0);
                drive(1, 64'h5550 + 64'(off), 2'(sz), 0, 1, 1, 1);
            end

        // R9: invalid request with a faulting shape
        tag = "R9 idle";
        drive(0, 64'h7, 2'd3, 0, 0, 1, 0);
        drive(0, 64'h7, 2'd3, 0, 0, 1, 0);

        // R8: vector wrap near the top of the address space
        tag = "R8 wrap";
        vec_base = 64'hFFFF_FFFF_FFFF_FF80;
        drive(1, 64'h9, 2'd3, 0, 0, 0, 0);
        drive(1, 64'h8, 2'd3, 0, 0, 0, 0);

        // R7/R10: mixed traffic
        tag = "R7/R10 mixed";
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) vec_base = {$urandom, $urandom};
            if (i % 131 == 0) attr_table = {$urandom, $urandom};
            drive(($urandom % 4) != 0, {$urandom, $urandom}, 2'($urandom), ($urandom % 3) == 0,
                  1'($urandom), 1'($urandom), int'($urandom % 8));
        end

        // R10: reset mid-run clears record
        tag = "R10 re-reset";
        drive(1, 64'h3, 2'd3, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) drive(0, 0, 0, 0, 0, 0, 0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule